// File: doc/BRIEF.md
# Automatic Idle Power-Off Controller

This controller decides, cycle by cycle, whether three switchable resources of an execution core should be powered: a secondary execution lane, a multiply unit and a divide unit. Software sets the policy through a 32-bit control register. Three bits are implemented and the remaining bits read back as zero. The controller drives one power request level per resource toward an external power sequencer. It watches the acknowledge level that the sequencer returns.

In automatic mode, the multiply and divide units stay powered only while they are used. An instruction that needs a unit raises that unit's request and restarts the unit's idle timer. The pipeline is held while the instruction waits for the unit to report power. After 256 cycles with no use, the request is dropped. A per-unit always-on bit overrides the timer. The secondary lane is switched by an enable bit. Clearing the bit stops issue to the lane, and power-off is requested only after the lane reports that it is empty. Setting the bit requests power again, and issue resumes once the lane reports that it is powered.

Top module: `idle_pwr_ctl`

## Requirements
- R1: Reading the control register returns the implemented bits in [2:0], and bits [31:3] read as 0. A write loads bits [2:0] from the write data and ignores bits [31:3]. The new value is readable in the cycle after the write cycle.
- R2: After reset the register reads 0x00000001. The multiply and divide requests are low, the lane request is high, and lane issue stays disabled until the lane acknowledge is seen.
- R3: When bit 1 (multiply) or bit 2 (divide) is 0, which selects automatic mode, a use pulse for that unit raises the unit's request from the next cycle.
- R4: The hold output is high in exactly those cycles in which some unit is being used while its acknowledge is low.
- R5: In automatic mode, the unit's request falls exactly 256 cycles after the last cycle that had a use. Every use restarts this count.
- R6: While the unit's mode bit is 1, which selects always-on, the unit's request is high whatever the timer says. The idle timer keeps running in this mode. After the bit returns to 0, the request stays high only until the running timer expires, and it falls at once if the timer has already expired.
- R7: When bit 0 is cleared, lane issue goes low one cycle after the register changes. The lane request stays high while the lane busy input is high, and it falls in the cycle after busy is seen low.
- R8: When bit 0 is set with the lane off, the lane request rises one cycle after the register changes. Issue is enabled in the cycle after the lane acknowledge is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Control register write data |
| reg_rdata_o | output | 32 | Control register read data |
| mul_use_i | input | 1 | A multiply instruction needs the unit this cycle |
| div_use_i | input | 1 | A divide instruction needs the unit this cycle |
| mul_pwr_ack_i | input | 1 | Multiply unit is powered |
| div_pwr_ack_i | input | 1 | Divide unit is powered |
| mul_pwr_req_o | output | 1 | Request power for the multiply unit |
| div_pwr_req_o | output | 1 | Request power for the divide unit |
| hold_o | output | 1 | Hold the pipeline |
| lane_busy_i | input | 1 | Secondary lane still has instructions in flight |
| lane_pwr_ack_i | input | 1 | Secondary lane is powered |
| lane_pwr_req_o | output | 1 | Request power for the secondary lane |
| lane_issue_en_o | output | 1 | Issue to the secondary lane is allowed |

## Verification
Hold follows the use and acknowledge inputs in the same cycle. Register read data and the unit requests settle one edge after a write or a use. An idle request drops on the 256th edge after the last use. Lane issue changes one edge after the register bit, and the lane request changes one edge after busy or acknowledge is sampled. A behavioural reference model advances on each rising edge from the inputs that were stable at that edge. Outputs are compared with the model at every falling edge. Directed checks count exact edge distances for the timeout and the lane handshakes. Stimulus changes just after the falling edge, so every sample sees settled values.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;
  localparam int unsigned CTRL_W     = 32;
  localparam int unsigned USED_W     = 3;
  localparam int unsigned BIT_LANE   = 0;
  localparam int unsigned BIT_MUL_ON = 1;
  localparam int unsigned BIT_DIV_ON = 2;
  localparam int unsigned N_UNITS    = 2;  // 0: multiply, 1: divide
  localparam logic [USED_W-1:0] CTRL_RST = 3'b001;

  typedef enum logic [1:0] {
    LANE_WAKE  = 2'd0,
    LANE_RUN   = 2'd1,
    LANE_DRAIN = 2'd2,
    LANE_OFF   = 2'd3
  } lane_state_e;
endpackage

// File: rtl/idle_pwr_reg.sv
module idle_pwr_reg
  import idle_pwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] rdata_o,
  output logic [USED_W-1:0] ctrl_o
);
  logic [USED_W-1:0] ctrl_q;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[CTRL_W-1:USED_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (we_i) ctrl_q <= wdata_i[USED_W-1:0];
  end

  assign rdata_o = {{(CTRL_W-USED_W){1'b0}}, ctrl_q};
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/idle_pwr_unit.sv
module idle_pwr_unit #(
  parameter int unsigned IDLE_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic use_i,
  input  logic keep_on_i,
  input  logic ack_i,
  output logic req_o,
  output logic hold_o
);
  localparam int unsigned CW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic          auto_q;
  logic [CW-1:0] idle_q;

  // timer runs whenever the auto request is up, whatever the mode bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q <= 1'b0;
      idle_q <= '0;
    end else if (use_i) begin
      auto_q <= 1'b1;
      idle_q <= '0;
    end else if (auto_q) begin
      if (idle_q == LAST) begin
        auto_q <= 1'b0;
        idle_q <= '0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign req_o  = auto_q | keep_on_i;
  assign hold_o = use_i & ~ack_i;
endmodule

// File: rtl/idle_pwr_lane.sv
module idle_pwr_lane
  import idle_pwr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic busy_i,
  input  logic ack_i,
  output logic req_o,
  output logic issue_en_o
);
  lane_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LANE_RUN:   if (!enable_i) state_d = LANE_DRAIN;
      LANE_DRAIN: if (enable_i) state_d = LANE_WAKE;
                  else if (!busy_i) state_d = LANE_OFF;
      LANE_OFF:   if (enable_i) state_d = LANE_WAKE;
      LANE_WAKE:  if (!enable_i) state_d = LANE_DRAIN;
                  else if (ack_i) state_d = LANE_RUN;
      default:    state_d = LANE_WAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LANE_WAKE;
    else         state_q <= state_d;
  end

  assign req_o      = (state_q != LANE_OFF);
  assign issue_en_o = (state_q == LANE_RUN);
endmodule

// File: rtl/idle_pwr_ctl.sv
module idle_pwr_ctl
  import idle_pwr_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  input  logic              mul_use_i,
  input  logic              div_use_i,
  input  logic              mul_pwr_ack_i,
  input  logic              div_pwr_ack_i,
  output logic              mul_pwr_req_o,
  output logic              div_pwr_req_o,
  output logic              hold_o,
  input  logic              lane_busy_i,
  input  logic              lane_pwr_ack_i,
  output logic              lane_pwr_req_o,
  output logic              lane_issue_en_o
);
  logic [USED_W-1:0]  ctrl;
  logic [N_UNITS-1:0] u_use, u_keep, u_ack, u_req, u_hold;

  idle_pwr_reg reg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl)
  );

  assign u_use  = {div_use_i, mul_use_i};
  assign u_ack  = {div_pwr_ack_i, mul_pwr_ack_i};
  assign u_keep = {ctrl[BIT_DIV_ON], ctrl[BIT_MUL_ON]};

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    idle_pwr_unit #(.IDLE_CYCLES(IDLE_CYCLES)) unit_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .use_i     (u_use[g]),
      .keep_on_i (u_keep[g]),
      .ack_i     (u_ack[g]),
      .req_o     (u_req[g]),
      .hold_o    (u_hold[g])
    );
  end

  assign mul_pwr_req_o = u_req[0];
  assign div_pwr_req_o = u_req[1];
  assign hold_o        = |u_hold;

  idle_pwr_lane lane_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (ctrl[BIT_LANE]),
    .busy_i     (lane_busy_i),
    .ack_i      (lane_pwr_ack_i),
    .req_o      (lane_pwr_req_o),
    .issue_en_o (lane_issue_en_o)
  );
endmodule

// File: rtl/idle_pwr_ctl_chk.sv
module idle_pwr_ctl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] reg_rdata_o,
  input logic        mul_use_i,
  input logic        div_use_i,
  input logic        mul_pwr_req_o,
  input logic        div_pwr_req_o,
  input logic        hold_o,
  input logic        lane_busy_i,
  input logic        lane_pwr_req_o,
  input logic        lane_issue_en_o
);
  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[31:3] == 29'd0);

  a_r3_mul_use_powers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_use_i |=> mul_pwr_req_o);

  a_r3_div_use_powers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_use_i |=> div_pwr_req_o);

  a_r4_hold_needs_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (mul_use_i || div_use_i));

  a_r5_mul_off_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mul_pwr_req_o) |-> !$past(mul_use_i));

  a_r5_div_off_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_pwr_req_o) |-> !$past(div_use_i));

  a_r7_off_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lane_pwr_req_o) |-> $past(!lane_busy_i && !lane_issue_en_o));

  a_r8_issue_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_issue_en_o |-> lane_pwr_req_o);
endmodule

bind idle_pwr_ctl idle_pwr_ctl_chk chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_rdata_o     (reg_rdata_o),
  .mul_use_i       (mul_use_i),
  .div_use_i       (div_use_i),
  .mul_pwr_req_o   (mul_pwr_req_o),
  .div_pwr_req_o   (div_pwr_req_o),
  .hold_o          (hold_o),
  .lane_busy_i     (lane_busy_i),
  .lane_pwr_req_o  (lane_pwr_req_o),
  .lane_issue_en_o (lane_issue_en_o)
);

// File: tb/idle_pwr_ctl_tb_top.sv
`timescale 1ns/1ps
module idle_pwr_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mul_use = 1'b0, div_use = 1'b0;
  logic        mul_ack = 1'b0, div_ack = 1'b0, lane_ack = 1'b0;
  logic        mul_req, div_req, hold, lane_req, issue_en;
  logic        lane_busy = 1'b0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  idle_pwr_ctl dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .reg_we_i (we), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
    .mul_use_i (mul_use), .div_use_i (div_use),
    .mul_pwr_ack_i (mul_ack), .div_pwr_ack_i (div_ack),
    .mul_pwr_req_o (mul_req), .div_pwr_req_o (div_req),
    .hold_o (hold), .lane_busy_i (lane_busy),
    .lane_pwr_ack_i (lane_ack), .lane_pwr_req_o (lane_req),
    .lane_issue_en_o (issue_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: 0 wake, 1 run, 2 drain, 3 off
  int m_reg, m_lane;
  bit m_auto [2];
  int m_idle [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 1; m_lane = 0;
      for (int i = 0; i < 2; i++) begin m_auto[i] = 0; m_idle[i] = 0; end
    end else begin
      bit en;
      bit u [2];
      en = m_reg[0];
      u[0] = mul_use; u[1] = div_use;
      case (m_lane)
        1: if (!en) m_lane = 2;
        2: if (en) m_lane = 0; else if (!lane_busy) m_lane = 3;
        3: if (en) m_lane = 0;
        default: if (!en) m_lane = 2; else if (lane_ack) m_lane = 1;
      endcase
      for (int i = 0; i < 2; i++) begin
        if (u[i]) begin m_auto[i] = 1; m_idle[i] = 0; end
        else if (m_auto[i]) begin
          if (m_idle[i] == 255) begin m_auto[i] = 0; m_idle[i] = 0; end
          else m_idle[i]++;
        end
      end
      if (we) m_reg = wdata & 32'h7;
    end
  end

  // per-clock compare, then sequencer stand-in (ack 3 cycles after req)
  int c_mul = 0, c_div = 0, c_lane = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 rdata", rdata, m_reg);
      chk("R3/R5/R6 mul_req", mul_req, m_auto[0] | m_reg[1]);
      chk("R3/R5/R6 div_req", div_req, m_auto[1] | m_reg[2]);
      chk("R4 hold", hold, (mul_use & ~mul_ack) | (div_use & ~div_ack));
      chk("R7/R8 lane_req", lane_req, m_lane != 3);
      chk("R7/R8 issue_en", issue_en, m_lane == 1);
    end
    if (mul_req) c_mul++; else c_mul = 0;
    if (div_req) c_div++; else c_div = 0;
    if (lane_req) c_lane++; else c_lane = 0;
    mul_ack  = rst_n && c_mul >= 3;
    div_ack  = rst_n && c_div >= 3;
    lane_ack = rst_n && c_lane >= 3;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] v);
    step(); we = 1'b1; wdata = v;
    step(); we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    #0.5;
    // R2 reset state
    chk("R2 rdata", rdata, 32'h1);
    chk("R2 mul_req", mul_req, 0);
    chk("R2 div_req", div_req, 0);
    chk("R2 lane_req", lane_req, 1);
    chk("R2 issue_en", issue_en, 0);
    repeat (6) step();
    chk("R2 issue after ack", issue_en, 1);

    // R1 upper bits ignored
    wr(32'hFFFF_FFF9);
    chk("R1 upper ignored", rdata, 32'h1);

    // R3/R4/R5 multiply auto
    step(); mul_use = 1'b1;
    #0.5 chk("R4 hold while powering", hold, 1);
    step();
    chk("R3 mul_req next cycle", mul_req, 1);
    while (!mul_ack) step();
    #0.5 chk("R4 hold released", hold, 0);
    mul_use = 1'b0;
    repeat (255) step();
    chk("R5 mul still on at 255", mul_req, 1);
    step();
    chk("R5 mul off at 256", mul_req, 0);

    // R5 restart by reuse
    step(); mul_use = 1'b1; step(); mul_use = 1'b0;
    repeat (200) step();
    mul_use = 1'b1; step(); mul_use = 1'b0;
    repeat (255) step();
    chk("R5 restarted timer", mul_req, 1);
    step();
    chk("R5 off after restart", mul_req, 0);

    // R6 divide always-on then back to auto
    step(); div_use = 1'b1; step(); div_use = 1'b0;
    wr(32'h5);
    repeat (300) step();
    chk("R6 div kept on", div_req, 1);
    wr(32'h1);
    chk("R6 div off after expired timer", div_req, 0);
    wr(32'h5);
    step(); div_use = 1'b1; step(); div_use = 1'b0;
    repeat (50) step();
    wr(32'h1);
    chk("R6 div on while timer runs", div_req, 1);
    repeat (260) step();
    chk("R6 div off at overflow", div_req, 0);

    // R7 lane drain
    lane_busy = 1'b1;
    wr(32'h0);
    step();
    chk("R7 issue stops", issue_en, 0);
    repeat (10) step();
    chk("R7 req held while busy", lane_req, 1);
    lane_busy = 1'b0;
    step();
    chk("R7 req drops after drain", lane_req, 0);

    // R8 wake
    wr(32'h1);
    step();
    chk("R8 req rises", lane_req, 1);
    chk("R8 no issue before ack", issue_en, 0);
    repeat (5) step();
    chk("R8 issue resumes", issue_en, 1);

    repeat (5) step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule